// File: doc/BRIEF.md
# Page-Mode Parallel ROM Burst Reader

This block fetches bursts from an asynchronous parallel ROM that offers a fast in-page read. A host hands over a start location, a count and a width selection (16-bit words or 8-bit bytes) through a valid/ready handshake. The block then drives the ROM address pins, its chip and output enables and its width-select pin. Each location is captured after a counted number of clock cycles, and the result goes out as a stream of single-cycle valid pulses.

A page is eight words, or sixteen bytes in byte mode. Only the lowest location bits change inside a page. The first read of a page waits the full random-access time. Each later read in the same page waits only the short page time. When a burst moves into a new page, the long wait applies again. In byte mode the least-significant location bit goes out on the pin that carries data bit 15 in word mode. The block drives that pin only while the ROM is enabled in byte mode.

The three delays are given in nanoseconds together with the clock period. They become cycle counts by ceiling division. After a burst the ROM enables go inactive, and no new request is taken until the bus-float time has passed.

Top module: `prom_burst_reader`

## Requirements
- R1: Out of reset `reqReady` is 1. A request is taken on a clock edge where `reqValid` and `reqReady` are both 1. `reqReady` stays 0 from the edge that accepts a non-zero burst until the float window after that burst ends.
- R2: A request with `reqLen` = 0 is accepted. It leaves `romCeN` at 1, produces no `outValid` pulse, and leaves `reqReady` at 1.
- R3: Word mode (`reqByteMode` = 0): `romAddr` is location bits [ADDR_W-1:0], `romByteN` is 1, `romLsbOe` is 0, and `outData` is the whole 16-bit word from the ROM.
- R4: Byte mode (`reqByteMode` = 1): `romAddr` is location bits [ADDR_W:1], `romLsbOut` is location bit 0, `romByteN` is 0, `romLsbOe` is 1 while `romCeN` is 0, and `outData` is {8'h00, ROM data bits [7:0]}.
- R5: The first item of a burst is presented with `outValid` exactly T_RAND cycles after the accepting edge, where T_RAND = ceil(RAND_NS / CLK_PERIOD_NS).
- R6: An item whose location is in the same page as the previous item follows it after exactly T_PAGE = ceil(PAGE_NS / CLK_PERIOD_NS) cycles. A page is location bits [ADDR_W-1:3] in word mode and [ADDR_W:4] in byte mode.
- R7: An item whose page differs from the previous item's page follows it after exactly T_RAND cycles.
- R8: A burst of length N gives exactly N items for locations start, start+1, and so on in ascending order. `outLast` is 1 only with the final item.
- R9: `romCeN` and `romOeN` go to 0 on the accepting edge and stay at 0 until the edge that captures the final item.
- R10: After the final item, `reqReady` rises exactly T_FLOAT = max(1, ceil(FLOAT_NS / CLK_PERIOD_NS)) cycles later, and `romCeN` stays at 1 for the whole of that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken |
| reqAddr | input | ADDR_W+1 | Start location; bit 0 is the byte bit in byte mode, and bit ADDR_W is unused in word mode |
| reqLen | input | LEN_W | Number of locations to read |
| reqByteMode | input | 1 | 1 selects byte reads, 0 selects word reads |
| romAddr | output | ADDR_W | ROM word address pins |
| romCeN | output | 1 | ROM chip enable, active low |
| romOeN | output | 1 | ROM output enable, active low |
| romByteN | output | 1 | ROM width select, 0 for byte mode |
| romLsbOut | output | 1 | Byte-select bit driven onto the shared data-15 pin |
| romLsbOe | output | 1 | Drive enable for the shared data-15 pin |
| romData | input | DATA_W | ROM data pins |
| outValid | output | 1 | Result item valid for one cycle |
| outData | output | DATA_W | Result item |
| outLast | output | 1 | Marks the final item of a burst |

## Verification
The bench builds the block with its defaults: a 22-bit word address, 8-word pages, a fast-grade 100/30/20 ns timing set and an 8 ns clock. These give waits of 13, 4 and 3 cycles. Because the long and short waits differ this much, an in-page item and a page-crossing item land on clearly different cycles. A ROM model in the bench returns a corrupt value whenever an address has been held for fewer cycles than its page state requires, so a wait that is one cycle too short shows up as bad data. Random starts and lengths of up to 24 often cross page boundaries in both modes. The 23-bit location space also lets the byte-select bit and the word/page split be exercised at random offsets.

// File: rtl/prom_pkg.sv
package prom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // take a new request
    logic capture;  // sample the ROM bus into the result register
    logic advance;  // step to the next location
  } dpStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/prom_burst_ctrl.sv
module prom_burst_ctrl
  import prom_pkg::*;
#(
  parameter int T_RAND  = 13,
  parameter int T_PAGE  = 4,
  parameter int T_FLOAT = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqLenNonZero,
  input  logic      lastItem,
  input  logic      nextSamePage,
  output logic      reqReady,
  output logic      romCeN,
  output logic      romOeN,
  output dpStrobe_t strobe
);

  localparam int WAIT_W  = $clog2(T_RAND + 1);
  localparam int FLOAT_W = $clog2(T_FLOAT + 1);

  ctlState_t          state;
  logic [WAIT_W-1:0]  waitCnt;
  logic [FLOAT_W-1:0] floatCnt;
  logic               enableN;

  always_comb begin
    reqReady       = (state == ST_IDLE);
    strobe.load    = (state == ST_IDLE) && reqValid && reqLenNonZero;
    strobe.capture = (state == ST_ACCESS) && (waitCnt == WAIT_W'(1));
    strobe.advance = strobe.capture && !lastItem;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      floatCnt <= '0;
      enableN  <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strobe.load) begin
            state   <= ST_ACCESS;
            enableN <= 1'b0;
            waitCnt <= WAIT_W'(T_RAND);
          end
        end
        ST_ACCESS: begin
          if (strobe.capture) begin
            if (lastItem) begin
              state    <= ST_FLOAT;
              enableN  <= 1'b1;
              floatCnt <= FLOAT_W'(T_FLOAT);
            end else begin
              waitCnt <= nextSamePage ? WAIT_W'(T_PAGE) : WAIT_W'(T_RAND);
            end
          end else begin
            waitCnt <= waitCnt - WAIT_W'(1);
          end
        end
        ST_FLOAT: begin
          if (floatCnt == FLOAT_W'(1)) state <= ST_IDLE;
          else floatCnt <= floatCnt - FLOAT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign romCeN = enableN;
  assign romOeN = enableN;

  // checker counter: cycles the ROM has been disabled, saturating
  logic [FLOAT_W-1:0] offCnt;
  always_ff @(posedge clk) begin
    if (!rstN) offCnt <= FLOAT_W'(T_FLOAT);
    else if (!romCeN) offCnt <= '0;
    else if (offCnt != FLOAT_W'(T_FLOAT)) offCnt <= offCnt + FLOAT_W'(1);
  end

  AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(romCeN) |-> offCnt >= FLOAT_W'(T_FLOAT)); // R10

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    !romCeN |-> !reqReady); // R1

  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqLenNonZero) |=> romCeN); // R2

endmodule

// File: rtl/prom_burst_dp.sv
module prom_burst_dp
  import prom_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int LEN_W     = 16,
  parameter int PAGE_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqByteMode,
  input  logic [DATA_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romByteN,
  output logic              romLsbOut,
  output logic              lastItem,
  output logic              nextSamePage,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast
);

  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  logic [ADDR_W:0]    loc;
  logic [ADDR_W:0]    locNext;
  logic [LEN_W-1:0]   remaining;
  logic               byteMode;
  logic [ADDR_W-1:0]  wordCur;
  logic [ADDR_W-1:0]  wordNext;
  logic [DATA_W-1:0]  laneData;

  function automatic logic [ADDR_W-1:0] wordOf(input logic [ADDR_W:0] l, input logic bm);
    return bm ? l[ADDR_W:1] : l[ADDR_W-1:0];
  endfunction

  always_comb begin
    locNext      = loc + (ADDR_W+1)'(1);
    wordCur      = wordOf(loc, byteMode);
    wordNext     = wordOf(locNext, byteMode);
    nextSamePage = (wordCur[ADDR_W-1:PAGE_BITS] == wordNext[ADDR_W-1:PAGE_BITS]);
    lastItem     = (remaining == LEN_W'(1));
    romAddr      = wordCur;
    romByteN     = !byteMode;
    romLsbOut    = byteMode & loc[0];
  end

  // lane 0 always passes; upper lanes are forced to zero in byte mode
  for (genvar g = 0; g < LANES; g++) begin : gLane
    if (g == 0) begin : gLow
      assign laneData[LANE_W-1:0] = romData[LANE_W-1:0];
    end else begin : gHigh
      assign laneData[g*LANE_W +: LANE_W] = byteMode ? '0 : romData[g*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loc       <= '0;
      remaining <= '0;
      byteMode  <= 1'b0;
      outValid  <= 1'b0;
      outLast   <= 1'b0;
      outData   <= '0;
    end else begin
      if (strobe.load) begin
        loc       <= reqAddr;
        remaining <= reqLen;
        byteMode  <= reqByteMode;
      end else if (strobe.advance) begin
        loc       <= locNext;
        remaining <= remaining - LEN_W'(1);
      end
      outValid <= strobe.capture;
      outLast  <= strobe.capture && lastItem;
      if (strobe.capture) outData <= laneData;
    end
  end

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid); // R8

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && $past(!strobe.load)) |-> $stable(romByteN)); // R4

endmodule

// File: rtl/prom_burst_reader.sv
module prom_burst_reader
  import prom_pkg::*;
#(
  parameter int ADDR_W        = 22,
  parameter int DATA_W        = 16,
  parameter int LEN_W         = 16,
  parameter int PAGE_BITS     = 3,
  parameter int CLK_PERIOD_NS = 8,
  parameter int RAND_NS       = 100,
  parameter int PAGE_NS       = 30,
  parameter int FLOAT_NS      = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqByteMode,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romCeN,
  output logic              romOeN,
  output logic              romByteN,
  output logic              romLsbOut,
  output logic              romLsbOe,
  input  logic [DATA_W-1:0] romData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast
);

  localparam int T_RAND_C  = ceilDiv(RAND_NS, CLK_PERIOD_NS);
  localparam int T_PAGE_C  = ceilDiv(PAGE_NS, CLK_PERIOD_NS);
  localparam int T_FLOAT_C = ceilDiv(FLOAT_NS, CLK_PERIOD_NS);
  localparam int T_RAND    = (T_RAND_C < 1) ? 1 : T_RAND_C;
  localparam int T_PAGE    = (T_PAGE_C < 1) ? 1 : T_PAGE_C;
  localparam int T_FLOAT   = (T_FLOAT_C < 1) ? 1 : T_FLOAT_C;
  localparam int HOLD_W    = $clog2(T_RAND + 2);

  dpStrobe_t strobe;
  logic      lastItem;
  logic      nextSamePage;

  prom_burst_ctrl #(
    .T_RAND (T_RAND),
    .T_PAGE (T_PAGE),
    .T_FLOAT(T_FLOAT)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqLenNonZero(reqLen != '0),
    .lastItem     (lastItem),
    .nextSamePage (nextSamePage),
    .reqReady     (reqReady),
    .romCeN       (romCeN),
    .romOeN       (romOeN),
    .strobe       (strobe)
  );

  prom_burst_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LEN_W    (LEN_W),
    .PAGE_BITS(PAGE_BITS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqLen      (reqLen),
    .reqByteMode (reqByteMode),
    .romData     (romData),
    .romAddr     (romAddr),
    .romByteN    (romByteN),
    .romLsbOut   (romLsbOut),
    .lastItem    (lastItem),
    .nextSamePage(nextSamePage),
    .outValid    (outValid),
    .outData     (outData),
    .outLast     (outLast)
  );

  assign romLsbOe = !romByteN && !romCeN;

  // checker: cycles the ROM bus has held one location while enabled
  logic [ADDR_W:0]   busNow;
  logic [ADDR_W:0]   busPrev;
  logic [HOLD_W-1:0] holdCnt;
  assign busNow = {romAddr, romLsbOut};
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busPrev <= '0;
      holdCnt <= '0;
    end else begin
      busPrev <= busNow;
      if (romCeN || busNow != busPrev) holdCnt <= '0;
      else if (holdCnt != '1) holdCnt <= holdCnt + HOLD_W'(1);
    end
  end

  AST_CAPTURE_SETTLED: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (int'($past(holdCnt)) + 2 >= T_PAGE)); // R6

  AST_LSB_ONLY_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    romLsbOe |-> (!romCeN && !romOeN)); // R4

endmodule

// File: tb/prom_burst_reader_tb.sv
module prom_stub_model #(
  parameter int ADDR_W   = 22,
  parameter int RAND_CYC = 13,
  parameter int PAGE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] romAddr,
  input  logic              romCeN,
  input  logic              romOeN,
  input  logic              romByteN,
  input  logic              romLsbOut,
  input  logic              romLsbOe,
  output logic [15:0]       romData
);
  logic [ADDR_W:0] bus, lastBus;
  logic            seen, open, hit;
  logic [ADDR_W-4:0] lastTag;
  int              cnt;
  int              need;

  function automatic logic [7:0] byteAt(input logic [ADDR_W:0] b);
    logic [31:0] h;
    h = 32'(b) * 32'h9E3779B1;
    return h[23:16] ^ h[7:0];
  endfunction

  assign bus = {romAddr, romLsbOe ? romLsbOut : 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN || romCeN) begin
      seen <= 1'b0; open <= 1'b0; hit <= 1'b0; cnt <= 0;
      lastBus <= '0; lastTag <= '0;
    end else if (!seen || bus != lastBus) begin
      seen    <= 1'b1;
      lastBus <= bus;
      cnt     <= 1;
      hit     <= open && (bus[ADDR_W:4] == lastTag);
      lastTag <= bus[ADDR_W:4];
      open    <= 1'b1;
    end else if (cnt < 1000) begin
      cnt <= cnt + 1;
    end
  end

  always_comb begin
    need = hit ? PAGE_CYC : RAND_CYC;
    if (romCeN || romOeN || !seen || bus != lastBus || cnt + 1 < need)
      romData = 16'hDEAD;
    else if (!romByteN)
      romData = {8'hC3, byteAt(bus)};
    else
      romData = {byteAt({romAddr, 1'b1}), byteAt({romAddr, 1'b0})};
  end
endmodule

module prom_burst_reader_tb;
  localparam int ADDR_W = 22;
  localparam int LEN_W  = 16;
  localparam int CLK_NS = 8;
  localparam int TR = (100 + CLK_NS - 1) / CLK_NS;
  localparam int TP = (30 + CLK_NS - 1) / CLK_NS;
  localparam int TF = (20 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [ADDR_W:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic reqByteMode = 1'b0;
  logic [ADDR_W-1:0] romAddr;
  logic romCeN, romOeN, romByteN, romLsbOut, romLsbOe;
  logic [15:0] romData;
  logic outValid, outLast;
  logic [15:0] outData;

  always #4 clk = ~clk;

  prom_burst_reader u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqByteMode(reqByteMode),
    .romAddr(romAddr), .romCeN(romCeN), .romOeN(romOeN), .romByteN(romByteN),
    .romLsbOut(romLsbOut), .romLsbOe(romLsbOe), .romData(romData),
    .outValid(outValid), .outData(outData), .outLast(outLast)
  );

  prom_stub_model #(.ADDR_W(ADDR_W), .RAND_CYC(TR), .PAGE_CYC(TP)) u_rom (
    .clk(clk), .rstN(rstN), .romAddr(romAddr), .romCeN(romCeN), .romOeN(romOeN),
    .romByteN(romByteN), .romLsbOut(romLsbOut), .romLsbOe(romLsbOe), .romData(romData)
  );

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] gotData [0:63];
  logic        gotLast [0:63];
  int          gotCyc  [0:63];
  int gotN = 0, ceLow = 0, modeErr = 0;
  logic curMode = 1'b0;

  always @(negedge clk) begin
    if (outValid && gotN < 64) begin
      gotData[gotN] = outData;
      gotLast[gotN] = outLast;
      gotCyc[gotN]  = cyc;
      gotN = gotN + 1;
    end
    if (!romCeN) begin
      ceLow = ceLow + 1;
      if (romOeN || romByteN == curMode || romLsbOe != curMode) modeErr = modeErr + 1;
    end
  end

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #1_200_000;
    tests = tests + 1;
    fails = fails + 1;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finishRun();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] refByte(input logic [ADDR_W:0] b);
    logic [31:0] h;
    h = 32'(b) * 32'h9E3779B1;
    return h[23:16] ^ h[7:0];
  endfunction

  function automatic logic [15:0] refData(input logic [ADDR_W:0] l, input logic bm);
    logic [ADDR_W-1:0] w;
    w = l[ADDR_W-1:0];
    if (bm) return {8'h00, refByte(l)};
    return {refByte({w, 1'b1}), refByte({w, 1'b0})};
  endfunction

  function automatic bit samePage(input logic [ADDR_W:0] a, input logic [ADDR_W:0] b,
                                  input logic bm);
    if (bm) return a[ADDR_W:4] == b[ADDR_W:4];
    return a[ADDR_W-1:3] == b[ADDR_W-1:3];
  endfunction

  task automatic runBurst(input logic [ADDR_W:0] addr, input int len, input logic bm);
    int accCyc, expCyc, readyCyc, guard, dataErr, timeErr, lastErr;
    logic [ADDR_W:0] l, prevL;
    @(negedge clk);
    guard = 0;
    while (!reqReady && guard < 1000) begin @(negedge clk); guard++; end
    gotN = 0; ceLow = 0; modeErr = 0; curMode = bm;
    reqAddr = addr; reqLen = LEN_W'(len); reqByteMode = bm; reqValid = 1'b1;
    @(negedge clk);
    accCyc = cyc;
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R1", "ready while busy", reqReady, 0);
    guard = 0;
    while (gotN < len && guard < len * TR + 100) begin @(negedge clk); guard++; end
    guard = 0;
    while (!reqReady && guard < 100) begin @(negedge clk); guard++; end
    readyCyc = cyc;
    chk(gotN == len, "R8", "item count", gotN, len);
    if (gotN != len) return;
    dataErr = 0; timeErr = 0; lastErr = 0;
    l = addr; prevL = addr; expCyc = accCyc + TR;
    for (int i = 0; i < len; i++) begin
      if (i > 0) expCyc = expCyc + (samePage(prevL, l, bm) ? TP : TR);
      if (gotData[i] != refData(l, bm)) begin
        dataErr++;
        if (dataErr == 1)
          chk(1'b0, bm ? "R4" : "R3", "item data", gotData[i], refData(l, bm));
      end
      if (gotCyc[i] != expCyc) begin
        timeErr++;
        if (timeErr == 1)
          chk(1'b0, i == 0 ? "R5" : "R6/R7", "item cycle", gotCyc[i] - accCyc, expCyc - accCyc);
      end
      if (gotLast[i] != (i == len - 1)) lastErr++;
      prevL = l;
      l = l + 1'b1;
    end
    chk(dataErr == 0, bm ? "R4" : "R3", "data mismatches", dataErr, 0);
    chk(timeErr == 0, "R6 R7", "timing mismatches", timeErr, 0);
    chk(lastErr == 0, "R8", "last flag mismatches", lastErr, 0);
    chk(ceLow == gotCyc[len-1] - accCyc, "R9", "enabled cycles", ceLow, gotCyc[len-1] - accCyc);
    chk(modeErr == 0, bm ? "R4" : "R3", "pin mode errors", modeErr, 0);
    chk(readyCyc - gotCyc[len-1] == TF, "R10", "float gap", readyCyc - gotCyc[len-1], TF);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20241);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "ready after reset", reqReady, 1);
    chk(romCeN == 1'b1 && romOeN == 1'b1, "R9", "enables after reset", {romCeN, romOeN}, 2'b11);
    chk(outValid == 1'b0, "R8", "no item after reset", outValid, 0);

    // R2: zero-length request
    reqAddr = 23'h12; reqLen = '0; reqByteMode = 1'b0; reqValid = 1'b1; gotN = 0; ceLow = 0;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b1, "R2", "ready after zero length", reqReady, 1);
    repeat (TR + 3) @(negedge clk);
    chk(gotN == 0, "R2", "items from zero length", gotN, 0);
    chk(ceLow == 0, "R2", "enabled cycles for zero length", ceLow, 0);

    runBurst(23'h0000_40, 1, 1'b0);   // R5 single word
    runBurst(23'h0001_00, 8, 1'b0);   // R6 full page, word mode
    runBurst(23'h0002_0C, 5, 1'b0);   // R7 crossing, word mode
    runBurst(23'h0003_00, 16, 1'b1);  // R4 R6 full byte page
    runBurst(23'h0004_1D, 6, 1'b1);   // R4 R7 crossing, byte mode odd start
    runBurst(23'h7FFF_FE, 3, 1'b1);   // location wrap, byte mode
    runBurst(23'h3FFF_FF, 2, 1'b0);   // word wrap, top bit ignored

    for (int k = 0; k < 40; k++) begin
      runBurst(($urandom() & 23'h7FFFFF), ($urandom() % 24) + 1, $urandom() & 1);
    end
    finishRun();
  end
endmodule